// File: doc/BRIEF.md
# Pipelined Multi-Master Read/Write Interconnect

This block joins several bus masters to several slaves. A request is a single-cycle handshake: the master raises a request with address, direction and write data, and holds it until the fabric raises accept in the same cycle. For a read, accept only closes the request phase. The data comes back later on a separate valid/data return, so each master can keep several reads in flight. Each slave chooses its own latency and may answer as early as the cycle after it accepted a read. Writes are posted: they are accepted through the same channel and nothing ever comes back for them.

The upper address bits pick the slave, so each slave owns a fixed, equal slice of the address space. A round-robin arbiter for each slave chooses among the masters that want that slave. Every accepted read pushes the issuing master's index into a return queue for that slave. Each return the slave gives is steered, with no added cycle, to the master at the head of that queue. A master keeps reads outstanding at only one slave at a time, so its data always arrives in the order it issued the reads.

Top module: `rd_pipe_fabric`

## Requirements
- R1: The target slave is the value of the top log2(N_SLV) address bits (N_SLV a power of two, at least 2). In the cycle a master is selected for a slave, that slave's request, address, write flag and write data carry the master's values.
- R2: `m_accept[m]` is high only in a cycle where master m's request is presented to its target slave and that slave's `s_ready` is high. A master holds its request until it is accepted.
- R3: Masters competing for one slave are served round-robin. After reset master 0 has first priority. After each completed transfer, priority moves to the master after the winner, so three masters that request all the time are accepted in the order 0, 1, 2, 0, 1, 2.
- R4: A slave's `s_rvalid` pulse is passed, with no added cycle and with the data unchanged, to the master whose accepted read is the oldest one still open at that slave. Reads therefore complete in issue order.
- R5: Each slave's return queue holds DEPTH entries, and a read to a slave whose queue is full is not accepted. A slot freed by a return can be used from the cycle after that return.
- R6: Writes (`m_we=1`) are accepted and forwarded with `s_we=1`. They take no queue slot and never raise `m_rvalid`.
- R7: While a master has reads open at one slave, its reads to any other slave are not accepted. This still holds in the cycle the last of those reads returns. Its writes stay allowed.
- R8: While `s_ready` is low, the selected request stays presented on the slave port and no accept is given.
- R9: After reset, with no requests, the fabric gives no accept, no slave request and no read return, and all return queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | N_MST | Request valid, one bit per master |
| m_we | input | N_MST | 1 = write, 0 = read, per master |
| m_addr | input | N_MST*AW | Request address, master m in slice m |
| m_wdata | input | N_MST*DW | Write data per master |
| m_accept | output | N_MST | Request accepted this cycle |
| m_rvalid | output | N_MST | Read data valid for master |
| m_rdata | output | N_MST*DW | Read data per master |
| s_req | output | N_SLV | Request presented to slave |
| s_we | output | N_SLV | Write flag to slave |
| s_addr | output | N_SLV*AW | Address to slave |
| s_wdata | output | N_SLV*DW | Write data to slave |
| s_ready | input | N_SLV | Slave can take the presented request |
| s_rvalid | input | N_SLV | Slave returns read data |
| s_rdata | input | N_SLV*DW | Slave read data |

## Verification
The bench builds the fabric with three masters and two slaves, an 8-bit address (bit 7 selects the slave), 16-bit data and a return-queue depth of 2. Three masters give a full round-robin cycle in which every master takes a turn. A depth of 2 lets two back-to-back reads fill a queue, so the full-queue stall and the slot freed by a return can be seen within a few cycles. The bench's slave models answer after 1 and after 3 cycles. The fast slave exercises a return in the very next cycle. The slow one keeps reads open long enough to show a master being held off from the other slave, and two masters' returns arriving in issue order.

// File: rtl/fab_pkg.sv
package fab_pkg;

    // Request direction carried through the fabric datapath
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    // Upper bound on masters handled by the arbiter search
    localparam int MAX_PORTS = 32;

    // Index width that never collapses to zero
    function automatic int clog2_min1(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

    // Round-robin search: first requester at or after ptr, -1 if none
    function automatic int rr_pick(input logic [MAX_PORTS-1:0] req,
                                   input int n, input int ptr);
        int idx;
        int found;
        found = -1;
        for (int i = 0; i < MAX_PORTS; i++) begin
            if (i < n) begin
                idx = ptr + i;
                if (idx >= n) idx = idx - n;
                if (found < 0 && req[idx]) found = idx;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/fab_rr_arb.sv
module fab_rr_arb
    import fab_pkg::*;
#(
    parameter  int N_MST = 2,
    localparam int IW    = clog2_min1(N_MST)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MST-1:0] req,
    input  logic             take,
    output logic             gnt_vld,
    output logic [IW-1:0]    gnt_idx
);

    logic [IW-1:0]        ptr;
    logic [MAX_PORTS-1:0] req_w;
    int                   pick;

    always_comb begin
        req_w              = '0;
        req_w[N_MST-1:0]   = req;
        pick               = rr_pick(req_w, N_MST, int'(ptr));
        gnt_vld            = (pick >= 0);
        gnt_idx            = gnt_vld ? IW'(pick) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take) begin
            ptr <= (int'(gnt_idx) == N_MST - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    // R3: the winner is always an active requester
    p_grant_requested_r3: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req[gnt_idx]);

    // R3: a transfer only happens on a valid grant
    p_take_granted_r3: assert property (@(posedge clk) disable iff (rst)
        take |-> gnt_vld);

    // R3: a winner that keeps requesting loses to any other requester next time
    p_no_repeat_r3: assert property (@(posedge clk) disable iff (rst)
        (take && ($countones(req) > 1)) |=>
            !(gnt_vld && gnt_idx == $past(gnt_idx) && $countones(req) > 1
              && $past(req) == req));

endmodule

// File: rtl/fab_id_fifo.sv
module fab_id_fifo
    import fab_pkg::*;
#(
    parameter  int DEPTH = 4,
    parameter  int W     = 1,
    localparam int PW    = clog2_min1(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R5: the fabric never pushes into a full queue
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R5: a full queue stays full until something is popped
    p_full_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

    // R5: occupancy never exceeds the depth
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/fab_rd_track.sv
module fab_rd_track
    import fab_pkg::*;
#(
    parameter  int N_SLV = 2,
    parameter  int DEPTH = 4,
    localparam int SIW   = clog2_min1(N_SLV),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_acc,
    input  logic [SIW-1:0] rd_slv,
    input  logic           ret,
    output logic           busy,
    output logic [SIW-1:0] cur_slv
);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cur_slv <= '0;
        end else begin
            cnt <= cnt + CW'(rd_acc) - CW'(ret);
            if (rd_acc) cur_slv <= rd_slv;
        end
    end

    // R7: a return only arrives for a master with a read open
    p_ret_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
        ret |-> busy);

    // R7: new reads only join reads open at the same slave
    p_one_target_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && busy) |-> (rd_slv == cur_slv));

    // R5: open reads of one master never exceed one slave's queue
    p_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/rd_pipe_fabric.sv
module rd_pipe_fabric
    import fab_pkg::*;
#(
    parameter  int N_MST = 2,
    parameter  int N_SLV = 2,
    parameter  int AW    = 16,
    parameter  int DW    = 32,
    parameter  int DEPTH = 4,
    localparam int MIW   = clog2_min1(N_MST),
    localparam int SIW   = clog2_min1(N_SLV)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_MST-1:0]    m_req,
    input  logic [N_MST-1:0]    m_we,
    input  logic [N_MST*AW-1:0] m_addr,
    input  logic [N_MST*DW-1:0] m_wdata,
    output logic [N_MST-1:0]    m_accept,
    output logic [N_MST-1:0]    m_rvalid,
    output logic [N_MST*DW-1:0] m_rdata,
    output logic [N_SLV-1:0]    s_req,
    output logic [N_SLV-1:0]    s_we,
    output logic [N_SLV*AW-1:0] s_addr,
    output logic [N_SLV*DW-1:0] s_wdata,
    input  logic [N_SLV-1:0]    s_ready,
    input  logic [N_SLV-1:0]    s_rvalid,
    input  logic [N_SLV*DW-1:0] s_rdata
);

    typedef struct packed {
        acc_kind_e       kind;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
    } mreq_t;

    // master side
    mreq_t                       mreq [N_MST];
    logic [N_MST-1:0][SIW-1:0]   tgt;
    logic [N_MST-1:0]            elig;
    logic [N_MST-1:0]            busy;
    logic [N_MST-1:0][SIW-1:0]   cur;
    logic [N_MST-1:0][N_SLV-1:0] src;

    // slave side
    logic [N_SLV-1:0][N_MST-1:0] arb_req;
    logic [N_SLV-1:0]            gvld;
    logic [N_SLV-1:0][MIW-1:0]   gidx;
    mreq_t                       fwd [N_SLV];
    logic [N_SLV-1:0]            xfer;
    logic [N_SLV-1:0]            push;
    logic [N_SLV-1:0]            pop;
    logic [N_SLV-1:0]            full;
    logic [N_SLV-1:0]            empty;
    logic [N_SLV-1:0][MIW-1:0]   head;

    // Decode and eligibility per master
    always_comb begin
        for (int m = 0; m < N_MST; m++) begin
            mreq[m].kind  = m_we[m] ? ACC_WRITE : ACC_READ;
            mreq[m].addr  = m_addr[m*AW +: AW];
            mreq[m].wdata = m_wdata[m*DW +: DW];
            tgt[m]        = m_addr[m*AW + AW - SIW +: SIW];
            elig[m]       = m_req[m] &&
                            (m_we[m] ||
                             (!full[tgt[m]] && (!busy[m] || cur[m] == tgt[m])));
        end
    end

    // Request vectors seen by each slave's arbiter
    always_comb begin
        for (int k = 0; k < N_SLV; k++) begin
            for (int m = 0; m < N_MST; m++) begin
                arb_req[k][m] = elig[m] && (tgt[m] == SIW'(k));
            end
        end
    end

    // Forwarding to slaves and return-queue control
    always_comb begin
        for (int k = 0; k < N_SLV; k++) begin
            fwd[k]               = mreq[gidx[k]];
            s_req[k]             = gvld[k];
            s_we[k]              = gvld[k] && (fwd[k].kind == ACC_WRITE);
            s_addr[k*AW +: AW]   = fwd[k].addr;
            s_wdata[k*DW +: DW]  = fwd[k].wdata;
            xfer[k]              = gvld[k] && s_ready[k];
            push[k]              = xfer[k] && (fwd[k].kind == ACC_READ);
            pop[k]               = s_rvalid[k] && !empty[k];
        end
    end

    // Accept and read-return steering per master
    always_comb begin
        for (int m = 0; m < N_MST; m++) begin
            m_accept[m]          = elig[m] && xfer[tgt[m]] &&
                                   (gidx[tgt[m]] == MIW'(m));
            m_rdata[m*DW +: DW]  = '0;
            for (int k = 0; k < N_SLV; k++) begin
                src[m][k]           = pop[k] && (head[k] == MIW'(m));
                m_rdata[m*DW +: DW] = m_rdata[m*DW +: DW] |
                                      ({DW{src[m][k]}} & s_rdata[k*DW +: DW]);
            end
            m_rvalid[m]          = |src[m];
        end
    end

    for (genvar k = 0; k < N_SLV; k++) begin : g_slv
        fab_rr_arb #(.N_MST(N_MST)) u_arb (
            .clk     (clk),
            .rst     (rst),
            .req     (arb_req[k]),
            .take    (xfer[k]),
            .gnt_vld (gvld[k]),
            .gnt_idx (gidx[k])
        );

        fab_id_fifo #(.DEPTH(DEPTH), .W(MIW)) u_ret (
            .clk   (clk),
            .rst   (rst),
            .push  (push[k]),
            .din   (gidx[k]),
            .pop   (pop[k]),
            .dout  (head[k]),
            .empty (empty[k]),
            .full  (full[k])
        );

        // R4: a slave only returns data for a read it holds open
        p_return_owned_r4: assert property (@(posedge clk) disable iff (rst)
            s_rvalid[k] |-> !empty[k]);
    end

    for (genvar m = 0; m < N_MST; m++) begin : g_mst
        fab_rd_track #(.N_SLV(N_SLV), .DEPTH(DEPTH)) u_trk (
            .clk     (clk),
            .rst     (rst),
            .rd_acc  (m_accept[m] && !m_we[m]),
            .rd_slv  (tgt[m]),
            .ret     (m_rvalid[m]),
            .busy    (busy[m]),
            .cur_slv (cur[m])
        );

        // R8: accept needs the target slave ready
        p_accept_ready_r8: assert property (@(posedge clk) disable iff (rst)
            m_accept[m] |-> s_ready[tgt[m]]);

        // R1: an accepted request is what the target slave sees
        p_fwd_match_r1: assert property (@(posedge clk) disable iff (rst)
            m_accept[m] |-> (s_req[tgt[m]] &&
                             s_addr[tgt[m]*AW +: AW] == m_addr[m*AW +: AW] &&
                             s_we[tgt[m]] == m_we[m]));

        // R7: returns for one master never come from two slaves at once
        p_one_source_r7: assert property (@(posedge clk) disable iff (rst)
            $onehot0(src[m]));
    end

endmodule

// File: tb/sim_rd_pipe_fabric.sv
module sim_rd_pipe_fabric;

    localparam int CLK_PERIOD = 10;
    localparam int NM    = 3;
    localparam int NS    = 2;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 2;
    localparam int LAT0  = 1;
    localparam int LAT1  = 3;

    typedef struct packed {
        logic [1:0]  mst;
        logic        we;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic        slv;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd0, 1'b0, 8'h12, 16'h0000, 1'b0},
        '{2'd1, 1'b0, 8'h85, 16'h0000, 1'b1},
        '{2'd2, 1'b1, 8'h33, 16'hBEEF, 1'b0},
        '{2'd0, 1'b1, 8'hF0, 16'h1234, 1'b1},
        '{2'd2, 1'b0, 8'h7F, 16'h0000, 1'b0},
        '{2'd1, 1'b0, 8'h00, 16'h0000, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NM-1:0]     m_req = '0;
    logic [NM-1:0]     m_we = '0;
    logic [NM*AW-1:0]  m_addr = '0;
    logic [NM*DW-1:0]  m_wdata = '0;
    logic [NM-1:0]     m_accept;
    logic [NM-1:0]     m_rvalid;
    logic [NM*DW-1:0]  m_rdata;
    logic [NS-1:0]     s_req;
    logic [NS-1:0]     s_we;
    logic [NS*AW-1:0]  s_addr;
    logic [NS*DW-1:0]  s_wdata;
    logic [NS-1:0]     s_ready = '1;
    logic [NS-1:0]     s_rvalid;
    logic [NS*DW-1:0]  s_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_pipe_fabric #(.N_MST(NM), .N_SLV(NS), .AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_accept(m_accept), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_rvalid(s_rvalid), .s_rdata(s_rdata)
    );

    // Slave models: fixed latency, data = {slave+1, address}
    logic [2:0]    pv [NS];
    logic [DW-1:0] pd [NS][3];

    function automatic int lat_of(input int k);
        return (k == 0) ? LAT0 : LAT1;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [7:0] a);
        return {8'(a[7] + 1'b1), a};
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < NS; k++) begin
            if (rst) begin
                pv[k] <= '0;
            end else begin
                pv[k]    <= {pv[k][1:0], s_req[k] & s_ready[k] & ~s_we[k]};
                pd[k][0] <= {8'(k + 1), s_addr[k*AW +: AW]};
                pd[k][1] <= pd[k][0];
                pd[k][2] <= pd[k][1];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NS; k++) begin
            s_rvalid[k]         = pv[k][lat_of(k)-1];
            s_rdata[k*DW +: DW] = pd[k][lat_of(k)-1];
        end
    end

    // Monitors: read returns per master and writes per slave
    logic [DW-1:0] rx_dat [NM][64];
    int            rx_cnt [NM];
    int            wr_cnt [NS];
    logic [AW-1:0] wr_addr [NS];
    logic [DW-1:0] wr_data [NS];

    initial begin
        for (int m = 0; m < NM; m++) rx_cnt[m] = 0;
        for (int k = 0; k < NS; k++) wr_cnt[k] = 0;
    end

    always @(posedge clk) begin
        if (!rst) begin
            for (int m = 0; m < NM; m++) begin
                if (m_rvalid[m]) begin
                    if (rx_cnt[m] < 64) rx_dat[m][rx_cnt[m]] = m_rdata[m*DW +: DW];
                    rx_cnt[m]++;
                end
            end
            for (int k = 0; k < NS; k++) begin
                if (s_req[k] && s_ready[k] && s_we[k]) begin
                    wr_cnt[k]++;
                    wr_addr[k] = s_addr[k*AW +: AW];
                    wr_data[k] = s_wdata[k*DW +: DW];
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst     = 1'b1;
        m_req   = '0;
        m_we    = '0;
        s_ready = '1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_req(input int m, input logic we,
                           input logic [7:0] a, input logic [15:0] d);
        m_req[m]            = 1'b1;
        m_we[m]             = we;
        m_addr[m*AW +: AW]  = a;
        m_wdata[m*DW +: DW] = d;
    endtask

    function automatic int rx_total();
        int t;
        t = 0;
        for (int m = 0; m < NM; m++) t += rx_cnt[m];
        return t;
    endfunction

    initial begin
        int base_rx;
        int base_tot;
        int base_wr;
        int nacc;
        int m;

        // R9: reset state
        do_reset();
        #1;
        chk(m_accept == '0, "R9 no accept after reset", 32'(m_accept), 0);
        chk(s_req == '0,    "R9 no slave request after reset", 32'(s_req), 0);
        chk(m_rvalid == '0, "R9 no return after reset", 32'(m_rvalid), 0);

        // R1, R2, R4, R6: vector table, one request at a time
        for (int i = 0; i < 6; i++) begin
            m        = int'(VEC[i].mst);
            base_rx  = rx_cnt[m];
            base_tot = rx_total();
            base_wr  = wr_cnt[VEC[i].slv];
            @(negedge clk);
            set_req(m, VEC[i].we, VEC[i].addr, VEC[i].wdata);
            #1;
            chk(m_accept == NM'(1 << m), "R2 accept to requester",
                32'(m_accept), 32'(1 << m));
            chk(s_req == NS'(1 << VEC[i].slv), "R1 slave select",
                32'(s_req), 32'(1 << VEC[i].slv));
            chk(s_addr[VEC[i].slv*AW +: AW] == VEC[i].addr, "R1 forwarded address",
                32'(s_addr[VEC[i].slv*AW +: AW]), 32'(VEC[i].addr));
            @(negedge clk);
            m_req[m] = 1'b0;
            repeat (5) @(negedge clk);
            if (VEC[i].we) begin
                chk(wr_cnt[VEC[i].slv] == base_wr + 1 && wr_data[VEC[i].slv] == VEC[i].wdata
                    && wr_addr[VEC[i].slv] == VEC[i].addr,
                    "R6 posted write reached slave", 32'(wr_data[VEC[i].slv]), 32'(VEC[i].wdata));
                chk(rx_total() == base_tot, "R6 write gives no return",
                    32'(rx_total()), 32'(base_tot));
            end else begin
                chk(rx_cnt[m] == base_rx + 1, "R4 one return to issuer",
                    32'(rx_cnt[m]), 32'(base_rx + 1));
                chk(rx_dat[m][base_rx] == exp_rd(VEC[i].addr), "R4 return data",
                    32'(rx_dat[m][base_rx]), 32'(exp_rd(VEC[i].addr)));
                chk(rx_total() == base_tot + 1, "R4 no return to others",
                    32'(rx_total()), 32'(base_tot + 1));
            end
        end

        // R3: three masters write slave 0 continuously
        do_reset();
        @(negedge clk);
        for (int j = 0; j < NM; j++) set_req(j, 1'b1, 8'h10, 16'(j));
        for (int c = 0; c < 6; c++) begin
            if (c > 0) @(negedge clk);
            #1;
            chk(m_accept == NM'(1 << (c % 3)), "R3 round-robin order",
                32'(m_accept), 32'(1 << (c % 3)));
        end
        @(negedge clk);
        m_req = '0;
        repeat (3) @(negedge clk);

        // R5: reads to slow slave fill the depth-2 queue
        do_reset();
        base_rx = rx_cnt[0];
        nacc    = 0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            set_req(0, 1'b0, 8'(8'h80 + nacc), 16'h0);
            #1;
            chk(m_accept[0] == ((c == 0 || c == 1 || c == 4) ? 1'b1 : 1'b0),
                "R5 accept while queue has room",
                32'(m_accept[0]), (c == 0 || c == 1 || c == 4) ? 1 : 0);
            if (m_accept[0]) nacc++;
        end
        @(negedge clk);
        m_req[0] = 1'b0;
        repeat (8) @(negedge clk);
        chk(rx_cnt[0] == base_rx + 3, "R5 three reads returned",
            32'(rx_cnt[0]), 32'(base_rx + 3));
        for (int j = 0; j < 3; j++)
            chk(rx_dat[0][base_rx + j] == exp_rd(8'(8'h80 + j)), "R4 R5 issue order",
                32'(rx_dat[0][base_rx + j]), 32'(exp_rd(8'(8'h80 + j))));

        // R7: master 0 open at slave 1 is held off from slave 0 reads
        do_reset();
        base_rx = rx_cnt[0];
        @(negedge clk);
        set_req(0, 1'b0, 8'h90, 16'h0);
        #1;
        chk(m_accept[0] == 1'b1, "R7 first read accepted", 32'(m_accept[0]), 1);
        @(negedge clk);
        set_req(0, 1'b0, 8'h10, 16'h0);
        #1;
        chk(m_accept[0] == 1'b0 && s_req[0] == 1'b0, "R7 other-slave read held",
            32'({s_req[0], m_accept[0]}), 0);
        @(negedge clk);
        set_req(0, 1'b1, 8'h10, 16'h5A5A);
        #1;
        chk(m_accept[0] == 1'b1, "R7 write still allowed", 32'(m_accept[0]), 1);
        @(negedge clk);
        set_req(0, 1'b0, 8'h10, 16'h0);
        #1;
        chk(m_accept[0] == 1'b0 && m_rvalid[0] == 1'b1,
            "R7 held in cycle of last return", 32'({m_rvalid[0], m_accept[0]}), 2);
        @(negedge clk);
        #1;
        chk(m_accept[0] == 1'b1, "R7 read accepted after return", 32'(m_accept[0]), 1);
        @(negedge clk);
        m_req[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk(rx_cnt[0] == base_rx + 2 && rx_dat[0][base_rx] == exp_rd(8'h90)
            && rx_dat[0][base_rx + 1] == exp_rd(8'h10),
            "R7 returns in order", 32'(rx_dat[0][base_rx + 1]), 32'(exp_rd(8'h10)));

        // R4: two masters read the slow slave back to back
        do_reset();
        @(negedge clk);
        set_req(0, 1'b0, 8'hA0, 16'h0);
        set_req(1, 1'b0, 8'hA1, 16'h0);
        #1;
        chk(m_accept == 3'b001, "R3 master 0 first after reset", 32'(m_accept), 1);
        @(negedge clk);
        m_req[0] = 1'b0;
        #1;
        chk(m_accept == 3'b010, "R3 master 1 next", 32'(m_accept), 2);
        @(negedge clk);
        m_req[1] = 1'b0;
        @(negedge clk);
        #1;
        chk(m_rvalid == 3'b001 && m_rdata[0 +: DW] == exp_rd(8'hA0),
            "R4 oldest read returns first", 32'(m_rdata[0 +: DW]), 32'(exp_rd(8'hA0)));
        @(negedge clk);
        #1;
        chk(m_rvalid == 3'b010 && m_rdata[DW +: DW] == exp_rd(8'hA1),
            "R4 second read to master 1", 32'(m_rdata[DW +: DW]), 32'(exp_rd(8'hA1)));

        // R8: slave 0 not ready
        do_reset();
        base_rx = rx_cnt[1];
        @(negedge clk);
        s_ready = 2'b10;
        set_req(1, 1'b0, 8'h05, 16'h0);
        for (int c = 0; c < 2; c++) begin
            if (c > 0) @(negedge clk);
            #1;
            chk(m_accept == '0 && s_req[0] == 1'b1 && s_addr[0 +: AW] == 8'h05,
                "R8 request held while not ready", 32'({s_req[0], m_accept}), 32'h8);
        end
        @(negedge clk);
        s_ready = 2'b11;
        #1;
        chk(m_accept == 3'b010, "R8 accepted once ready", 32'(m_accept), 2);
        @(negedge clk);
        m_req[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_cnt[1] == base_rx + 1 && rx_dat[1][base_rx] == exp_rd(8'h05),
            "R8 data after stall", 32'(rx_dat[1][base_rx]), 32'(exp_rd(8'h05)));

        summary();
        $finish;
    end

endmodule